// File: doc/BRIEF.md
# Mirrored Video Memory with Mode-Filtered Byte Writes

This block is the video memory of a display subsystem. It holds three equal segments of storage (two segments of background data followed by one segment shared with object data), and answers a processor bus port that reads 8, 16 or 32 bits and writes 16 or 32 bits in little-endian order. The processor sees a window of four segments that repeats for the whole address space. Offsets in the fourth segment of that window land on the third physical segment, so the last segment appears twice.

Byte writes get special treatment. A byte write that is accepted does not touch one byte: the byte is stored into both halves of the aligned halfword. Whether a byte write is accepted depends on a 3-bit background mode that arrives with the request. In the tiled modes (0, 1 and 2) no byte write may reach the third segment. In the bitmap modes (3 to 7) the background area extends half a segment further, and byte writes above that point are dropped. A second read-only port lets the renderer fetch aligned words every cycle through the same mirrored map.

The segment size is the parameter `SEG_AW` (log2 of the segment size in bytes). `SEG_AW = 15` gives 32 KiB segments, a 96 KiB store and a 128 KiB window. The smaller default keeps elaboration light.

Top module: `vram_mirror_top`

## Requirements
- R1: The store holds 3·2^SEG_AW bytes, and every aligned word location in it can be written and read back independently of all the others.
- R2: Only the low SEG_AW+2 bits of an address are used, so the window repeats every 4·2^SEG_AW bytes.
- R3: A masked offset below 3·2^SEG_AW is used as the physical byte index unchanged. An offset in the fourth segment maps to 2·2^SEG_AW plus its low SEG_AW bits, so it aliases the third segment.
- R4: The size codes are 0 = byte, 1 = halfword and 2 = word. Data is little-endian (the lowest address holds bits 7:0), and byte and halfword reads are zero-extended to 32 bits.
- R5: In modes 0, 1 and 2, a byte write whose mapped index is at or above 2·2^SEG_AW is dropped and leaves the memory unchanged.
- R6: In modes 3 to 7, a byte write whose mapped index is at or above 2·2^SEG_AW + 2^(SEG_AW-1) is dropped and leaves the memory unchanged.
- R7: An accepted byte write stores its byte into both bytes of the halfword at the index with bit 0 cleared.
- R8: Reset is synchronous and active high. It clears every storage location to zero and deasserts rd_valid.
- R9: rd_valid is high in exactly the cycle after a read request, and rd_data carries the read result in that cycle.
- R10: Halfword accesses ignore index bit 0, and word accesses ignore index bits 1:0, for both reads and writes.
- R11: bg_mode is sampled in the same cycle as the write request. A mode change affects only that request and later ones.
- R12: The renderer port returns, one cycle after rnd_addr is presented, the aligned word at its mirrored index. If a processor write hits that word in the same cycle, the renderer port returns the data from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Processor byte address |
| req_wdata | input | 32 | Write data, right-aligned for byte and halfword |
| bg_mode | input | 3 | Background mode used to filter byte writes |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result, zero-extended |
| rnd_addr | input | ADDR_W | Renderer byte address |
| rnd_data | output | 32 | Renderer word, one cycle after rnd_addr |

## Verification
The hardest case to reach is a byte write that lands exactly on the bitmap-mode limit, or one segment beyond it, through an address in the aliased fourth segment, while the mode flips between tiled and bitmap on consecutive cycles. The stimulus reaches this case with directed writes on both sides of each limit, issued through direct, aliased and wrapped addresses and followed by readback of the whole halfword. After that comes a long random run in which addresses, sizes and modes change every cycle, and the renderer port probes a random word in every one of those cycles.

// File: rtl/vram_pkg.sv
package vram_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Registered descriptor of a pending read, used to format the result.
    typedef struct packed {
        logic      valid;
        acc_size_e size;
        logic [1:0] off;
    } rd_tag_t;

    // Lane-level write command produced by the write controller.
    typedef struct packed {
        logic [3:0]  we;
        logic [31:0] lanes;
    } wr_cmd_t;

    // Tiled modes keep the object area at two segments.
    function automatic logic mode_is_tiled(input logic [2:0] mode);
        return mode <= 3'd2;
    endfunction

    function automatic logic [3:0] half_lanes(input logic upper);
        return upper ? 4'b1100 : 4'b0011;
    endfunction

endpackage

// File: rtl/vram_addr_map.sv
module vram_addr_map
    import vram_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_AW = 8,
    localparam int IDX_W = SEG_AW + 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    logic [IDX_W-1:0] wrapped;

    always_comb begin
        wrapped = addr[IDX_W-1:0];
        if (wrapped[IDX_W-1:IDX_W-2] == 2'b11)
            idx = {2'b10, wrapped[SEG_AW-1:0]};
        else
            idx = wrapped;
    end
endmodule

// File: rtl/vram_write_ctl.sv
module vram_write_ctl
    import vram_pkg::*;
#(
    parameter int SEG_AW = 8,
    localparam int IDX_W = SEG_AW + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             write,
    input  acc_size_e        size,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    input  logic [2:0]       mode,
    output wr_cmd_t          cmd
);
    localparam int OBJ_BASE  = 2 << SEG_AW;
    localparam int BMP_LIMIT = OBJ_BASE + (1 << (SEG_AW - 1));

    logic byte_ok;

    always_comb begin
        byte_ok = mode_is_tiled(mode) ? (int'(idx) < OBJ_BASE)
                                      : (int'(idx) < BMP_LIMIT);
        cmd.we    = 4'b0000;
        cmd.lanes = wdata;
        if (valid && write) begin
            unique case (size)
                SZ_WORD: begin
                    cmd.we    = 4'b1111;
                    cmd.lanes = wdata;
                end
                SZ_HALF: begin
                    cmd.we    = half_lanes(idx[1]);
                    cmd.lanes = {wdata[15:0], wdata[15:0]};
                end
                SZ_BYTE: begin
                    cmd.we    = byte_ok ? half_lanes(idx[1]) : 4'b0000;
                    cmd.lanes = {4{wdata[7:0]}};
                end
                default: cmd.we = 4'b0000;
            endcase
        end
    end

    // R5
    tiled_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && write && size == SZ_BYTE && mode <= 3'd2 && int'(idx) >= OBJ_BASE)
            |-> cmd.we == 4'b0000);

    // R6
    bitmap_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && write && size == SZ_BYTE && mode > 3'd2 && int'(idx) >= BMP_LIMIT)
            |-> cmd.we == 4'b0000);

    // R7
    byte_repl_chk: assert property (@(posedge clk) disable iff (rst)
        (size == SZ_BYTE && cmd.we != 4'b0000)
            |-> ($countones(cmd.we) == 2 && cmd.lanes[15:8] == wdata[7:0]
                 && cmd.lanes[7:0] == wdata[7:0]));

    // R10
    half_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && write && size == SZ_HALF)
            |-> (cmd.we == 4'b0011 || cmd.we == 4'b1100));

endmodule

// File: rtl/vram_store.sv
module vram_store
    import vram_pkg::*;
#(
    parameter int SEG_AW = 8,
    localparam int WORDS = 3 << (SEG_AW - 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    input  logic [SEG_AW-1:0] widx,
    input  logic [SEG_AW-1:0] ra,
    input  logic [SEG_AW-1:0] rb,
    output logic [31:0]       qa,
    output logic [31:0]       qb
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++)
                mem[i] <= '0;
            qa <= '0;
            qb <= '0;
        end else begin
            qa <= mem[ra];
            qb <= mem[rb];
            for (int l = 0; l < 4; l++)
                if (cmd.we[l])
                    mem[widx][l*8 +: 8] <= cmd.lanes[l*8 +: 8];
        end
    end

    // R2
    store_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.we != 4'b0000) |-> int'(widx) < WORDS);

    // R3
    read_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(ra) < WORDS && int'(rb) < WORDS);

endmodule

// File: rtl/vram_mirror_top.sv
module vram_mirror_top
    import vram_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [2:0]        bg_mode,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic [ADDR_W-1:0] rnd_addr,
    output logic [31:0]       rnd_data
);
    localparam int IDX_W = SEG_AW + 2;

    acc_size_e        size;
    logic [IDX_W-1:0] cpu_idx;
    logic [IDX_W-1:0] rnd_idx;
    wr_cmd_t          wcmd;
    logic [31:0]      cpu_word;
    logic [31:0]      shifted;
    rd_tag_t          tag_q;

    assign size = acc_size_e'(req_size);

    vram_addr_map #(.ADDR_W(ADDR_W), .SEG_AW(SEG_AW)) u_map_cpu (
        .addr (req_addr),
        .idx  (cpu_idx)
    );

    vram_addr_map #(.ADDR_W(ADDR_W), .SEG_AW(SEG_AW)) u_map_rnd (
        .addr (rnd_addr),
        .idx  (rnd_idx)
    );

    vram_write_ctl #(.SEG_AW(SEG_AW)) u_wctl (
        .clk   (clk),
        .rst   (rst),
        .valid (req_valid),
        .write (req_write),
        .size  (size),
        .idx   (cpu_idx),
        .wdata (req_wdata),
        .mode  (bg_mode),
        .cmd   (wcmd)
    );

    vram_store #(.SEG_AW(SEG_AW)) u_store (
        .clk  (clk),
        .rst  (rst),
        .cmd  (wcmd),
        .widx (cpu_idx[IDX_W-1:2]),
        .ra   (cpu_idx[IDX_W-1:2]),
        .rb   (rnd_idx[IDX_W-1:2]),
        .qa   (cpu_word),
        .qb   (rnd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            tag_q.valid <= req_valid && !req_write;
            tag_q.size  <= size;
            tag_q.off   <= cpu_idx[1:0];
        end
    end

    always_comb begin
        shifted = cpu_word >> {tag_q.off, 3'b000};
        unique case (tag_q.size)
            SZ_BYTE: rd_data = {24'h0, shifted[7:0]};
            SZ_HALF: rd_data = {16'h0, tag_q.off[1] ? cpu_word[31:16] : cpu_word[15:0]};
            default: rd_data = cpu_word;
        endcase
    end

    assign rd_valid = tag_q.valid;

    // R9
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);

    // R9
    no_spurious_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rd_valid);

    // R4
    zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && tag_q.size == SZ_BYTE) |-> rd_data[31:8] == 24'h0);

endmodule

// File: tb/tb_vram_mirror_top.sv
`timescale 1ns/1ps
module tb_vram_mirror_top;
    localparam int SEG_AW = 8;
    localparam int SEG    = 1 << SEG_AW;
    localparam int STORE  = 3 * SEG;

    logic        clk = 0;
    logic        rst = 1;
    logic        req_valid = 0;
    logic        req_write = 0;
    logic [1:0]  req_size = 0;
    logic [31:0] req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic [2:0]  bg_mode = 0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [31:0] rnd_addr = 0;
    logic [31:0] rnd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] model [STORE];

    vram_mirror_top #(.ADDR_W(32), .SEG_AW(SEG_AW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .bg_mode(bg_mode), .rd_valid(rd_valid), .rd_data(rd_data),
        .rnd_addr(rnd_addr), .rnd_data(rnd_data)
    );

    always #10 clk = ~clk;

    function automatic int mir(input logic [31:0] a);
        int w;
        w = int'(a % (4 * SEG));
        return (w < STORE) ? w : 2 * SEG + (w % SEG);
    endfunction

    function automatic logic [31:0] m_read(input int sz, input logic [31:0] a);
        int i;
        i = mir(a);
        if (sz == 0) return {24'h0, model[i]};
        if (sz == 1) begin
            i = i & ~1;
            return {16'h0, model[i+1], model[i]};
        end
        i = i & ~3;
        return {model[i+3], model[i+2], model[i+1], model[i]};
    endfunction

    task automatic m_write(input int sz, input logic [31:0] a, input logic [31:0] d, input int md);
        int i;
        int lim;
        i = mir(a);
        if (sz == 2) begin
            i = i & ~3;
            for (int k = 0; k < 4; k++) model[i+k] = d[k*8 +: 8];
        end else if (sz == 1) begin
            i = i & ~1;
            model[i] = d[7:0];
            model[i+1] = d[15:8];
        end else begin
            lim = (md <= 2) ? 2 * SEG : 2 * SEG + SEG / 2;
            if (i < lim) begin
                model[i & ~1] = d[7:0];
                model[i | 1]  = d[7:0];
            end
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input bit v, input bit w, input int sz, input logic [31:0] a,
                        input logic [31:0] d, input int md, input logic [31:0] ra,
                        input string tag);
        bit ev;
        logic [31:0] er;
        logic [31:0] en;
        req_valid = v; req_write = w; req_size = 2'(sz); req_addr = a;
        req_wdata = d; bg_mode = 3'(md); rnd_addr = ra;
        ev = v && !w;
        er = ev ? m_read(sz, a) : 32'h0;
        en = m_read(2, ra);
        if (v && w) m_write(sz, a, d, md);
        @(posedge clk);
        #1;
        check(rd_valid == ev, {tag, " rd_valid"}, {31'h0, rd_valid}, {31'h0, ev});
        if (ev) check(rd_data == er, tag, rd_data, er);
        check(rnd_data == en, "R12 renderer", rnd_data, en);
        req_valid = 0;
    endtask

    task automatic wr(input int sz, input logic [31:0] a, input logic [31:0] d, input int md, input string tag);
        step(1, 1, sz, a, d, md, $urandom, tag);
    endtask

    task automatic rd(input int sz, input logic [31:0] a, input string tag);
        step(1, 0, sz, a, 0, 0, $urandom, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < STORE; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        // R8 reset state
        check(rd_valid == 1'b0, "R8 rd_valid after reset", {31'h0, rd_valid}, 32'h0);
        rd(2, 32'h0, "R8");
        rd(2, 32'h2FC, "R8");
        rd(1, 32'h17E, "R8");

        // R4 little-endian
        wr(2, 32'h010, 32'h44332211, 0, "R4");
        rd(0, 32'h012, "R4");
        rd(1, 32'h012, "R4");
        rd(2, 32'h010, "R4");
        rd(0, 32'h011, "R4");

        // R10 forced alignment
        wr(2, 32'h021, 32'hA1B2C3D4, 0, "R10");
        rd(2, 32'h020, "R10");
        wr(1, 32'h033, 32'h0000BEEF, 0, "R10");
        rd(2, 32'h030, "R10");
        rd(1, 32'h031, "R10");

        // R3 aliasing of the fourth segment
        wr(2, 32'h340, 32'hCAFE0001, 0, "R3");
        rd(2, 32'h240, "R3");
        wr(2, 32'h2C4, 32'h12345678, 0, "R3");
        rd(2, 32'h3C4, "R3");

        // R2 window repeat
        wr(2, 32'h450, 32'h0BADF00D, 0, "R2");
        rd(2, 32'h050, "R2");
        rd(2, 32'hFFFF_F050, "R2");

        // R7 byte replication
        wr(0, 32'h061, 32'h0000005A, 0, "R7");
        rd(1, 32'h060, "R7");
        wr(0, 32'h1FF, 32'h000000C3, 2, "R7");
        rd(2, 32'h1FC, "R7");

        // R5 tiled modes drop object-area byte writes
        wr(2, 32'h200, 32'h11111111, 0, "R5");
        wr(0, 32'h200, 32'h000000EE, 0, "R5");
        rd(2, 32'h200, "R5");
        wr(0, 32'h2FF, 32'h000000EE, 2, "R5");
        rd(1, 32'h2FE, "R5");

        // R6 bitmap limit
        wr(0, 32'h23F, 32'h00000077, 3, "R6");
        rd(1, 32'h23E, "R6");
        wr(2, 32'h280, 32'h22222222, 3, "R6");
        wr(0, 32'h280, 32'h00000099, 3, "R6");
        rd(2, 32'h280, "R6");
        wr(0, 32'h27F, 32'h00000066, 7, "R6");
        rd(1, 32'h27E, "R6");
        wr(0, 32'h380, 32'h00000055, 5, "R6");
        rd(2, 32'h280, "R6");

        // R11 mode sampled with each request
        wr(0, 32'h250, 32'h000000AB, 4, "R11");
        wr(0, 32'h252, 32'h000000CD, 1, "R11");
        wr(0, 32'h254, 32'h000000EF, 6, "R11");
        rd(2, 32'h250, "R11");
        rd(2, 32'h254, "R11");

        // R12 read-before-write on the renderer port
        step(1, 1, 2, 32'h070, 32'hDEADBEEF, 0, 32'h070, "R12");
        step(0, 0, 0, 0, 0, 0, 32'h470, "R12");

        // R1 every word independent
        for (int i = 0; i < STORE / 4; i++) wr(2, 32'(i * 4), 32'(i * 32'h01010101 + 7), 0, "R1");
        for (int i = 0; i < STORE / 4; i++) rd(2, 32'(i * 4), "R1");

        // Random traffic (R2..R12 against the model)
        for (int n = 0; n < 4000; n++) begin
            int sz;
            sz = int'($urandom % 3);
            step($urandom % 4 != 0, $urandom % 2 == 1, sz, $urandom % 2048,
                 $urandom, int'($urandom % 8), $urandom % 2048, "R9 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule